// File: doc/BRIEF.md
# Programmable Display Timing Engine

This block generates the sync and enable timing for a display interface from a set of programmed registers. Software writes the horizontal total, the sync pulse widths, a display window and an optional active sub-window through a small write port, then sets the run bit. While it runs, the engine walks two counters: a horizontal pixel counter, and a frame position counter that counts pixel clocks from the start of the vertical sync pulse. Horizontal decisions compare against the pixel counter. Vertical decisions compare against the frame position, so the vertical period, the vsync width and the vertical window edges are all given in pixel clocks. Any hsync skew is folded in by software when it computes those values.

The outputs are hsync, vsync and data enable, each with its own polarity, a one-cycle fetch pulse at a programmed frame position, and the pixel value. Inside the active window the pixel is the incoming pixel, or the underflow colour when the input is not valid. In the rest of the display window it is the border colour, and outside the display window it is zero. A frame counter and a line counter can be read back. Timing registers written while the engine runs take effect at the next frame boundary.

Top module: `disp_timing_engine`

## Requirements
- R1: Registers are written through `wr_en`/`wr_addr`/`wr_data` and read back on `rd_data` one clock after `rd_addr` is presented. Word addresses: 0 run (bit 0), 1 mode, 2 hsync control, 3 vertical period, 4 vsync width, 5 display horizontal window, 6 display vertical start, 7 display vertical end, 8 active horizontal window, 9 active vertical start, 10 active vertical end, 11 border colour, 12 underflow colour, 13 polarity, 14 counter enable, 15 fetch position, 16 frame count (read only), 17 line count (read only). After reset every register reads zero.
- R2: The hsync control register holds the horizontal total in bits 31:16 and the hsync width in bits 15:0. hsync repeats every horizontal-total clocks and is active for the hsync width.
- R3: vsync is active for the vsync-width register value in clocks. The frame repeats every vertical-period clocks, and the position counter restarts at 0 when vsync starts.
- R4: Data enable is active where the pixel counter lies in [start, end] of the display horizontal register (start in bits 15:0, end in bits 31:16) and the frame position lies in [display vertical start, display vertical end], both bounds inclusive.
- R5: The vertical window edges are compared against the frame position and not against a line number, so a start value that is not a multiple of the horizontal total (for example one that includes an hsync skew) moves the first enabled pixel by exactly that many clocks.
- R6: Polarity register bit 0 inverts hsync, bit 1 inverts vsync and bit 2 inverts data enable. A stopped engine drives each output at its inactive level.
- R7: Mode bit 29 limits the active area horizontally to the active horizontal register range (start in bits 15:0, end in bits 31:16). Mode bit 30 limits it vertically to the active vertical start/end range. Pixels in the display window but outside the active area carry the border colour.
- R8: Inside the active area, the output pixel is `pix_in` when `pix_valid` is high and the underflow colour when it is low.
- R9: With mode bit 31 set, `fetch_o` pulses for one clock per frame at the frame position held in the fetch register. With bit 31 clear it never pulses.
- R10: Counter enable bit 0 lets the frame counter advance once per frame wrap. Bit 1 lets the line counter advance at each horizontal wrap. The line counter restarts at 0 each frame. With a bit clear, its counter holds.
- R11: When the run bit is cleared, the frame and line counts read zero and data enable stays inactive.
- R12: Timing, mode and polarity registers written while running take effect at the next frame wrap. While stopped, they take effect at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 5 | Register read word address |
| rd_data | output | 32 | Registered read data |
| pix_in | input | CW | Incoming pixel |
| pix_valid | input | 1 | Incoming pixel is valid |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| fetch_o | output | 1 | Fetch-start pulse |
| pixel_o | output | CW | Output pixel |

## Verification
The bench goes after the vertical window with a start value that is not a whole number of lines. A design that compares against a line number would put the first enabled pixel on a line boundary rather than at the programmed clock. It also writes a new horizontal total in the middle of a frame. An engine without shadow registers would change the hsync period at once rather than after the next vsync. Other cases are an active sub-window enabled on one axis and on both axes, where a wrong mask miscounts the split between border and active pixels, and inverted polarities, where an engine that inverts only the active phase gets the idle levels wrong. Finally, the counters are read after a stop, after a counter enable is cleared, and a known number of frames apart, which shows counters that fail to clear, fail to hold, or step twice.

// File: rtl/dte_pkg.sv
package dte_pkg;
  localparam int REG_W   = 32;
  localparam int FIELD_W = 16;
  localparam int ADDR_W  = 5;

  localparam int A_RUN     = 0;
  localparam int A_MODE    = 1;
  localparam int A_HSYNC   = 2;
  localparam int A_VPER    = 3;
  localparam int A_VPW     = 4;
  localparam int A_DISP_H  = 5;
  localparam int A_DISP_VS = 6;
  localparam int A_DISP_VE = 7;
  localparam int A_ACT_H   = 8;
  localparam int A_ACT_VS  = 9;
  localparam int A_ACT_VE  = 10;
  localparam int A_BORDER  = 11;
  localparam int A_UFLOW   = 12;
  localparam int A_POLAR   = 13;
  localparam int A_CNT_EN  = 14;
  localparam int A_FETCH   = 15;
  localparam int A_FRAMES  = 16;
  localparam int A_LINES   = 17;

  // mode[0]: active H limit (bit 29), mode[1]: active V limit (bit 30), mode[2]: fetch (bit 31)
  localparam int MODE_LSB = 29;

  typedef struct packed {
    logic [2:0]         mode;
    logic [2:0]         pol;
    logic [FIELD_W-1:0] htot;
    logic [FIELD_W-1:0] hsw;
    logic [FIELD_W-1:0] dh_end;
    logic [FIELD_W-1:0] dh_start;
    logic [FIELD_W-1:0] ah_end;
    logic [FIELD_W-1:0] ah_start;
    logic [REG_W-1:0]   vper;
    logic [REG_W-1:0]   vpw;
    logic [REG_W-1:0]   dvs;
    logic [REG_W-1:0]   dve;
    logic [REG_W-1:0]   avs;
    logic [REG_W-1:0]   ave;
    logic [REG_W-1:0]   fetch;
  } timing_t;
endpackage

// File: rtl/dte_regs.sv
module dte_regs
  import dte_pkg::*;
#(
  parameter int CW     = 24,
  parameter int CNT_W  = 32,
  parameter int LINE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic              frame_wrap,
  input  logic [CNT_W-1:0]  frame_cnt,
  input  logic [LINE_W-1:0] line_cnt,
  output logic              run,
  output logic [1:0]        cnt_en,
  output logic [CW-1:0]     border,
  output logic [CW-1:0]     uflow,
  output timing_t           act
);
  timing_t live;

  always_ff @(posedge clk) begin
    if (rst) begin
      live   <= '0;
      run    <= 1'b0;
      cnt_en <= 2'b00;
      border <= '0;
      uflow  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_W'(A_RUN):     run <= wr_data[0];
        ADDR_W'(A_MODE):    live.mode <= wr_data[MODE_LSB +: 3];
        ADDR_W'(A_HSYNC):   begin
          live.htot <= wr_data[FIELD_W +: FIELD_W];
          live.hsw  <= wr_data[FIELD_W-1:0];
        end
        ADDR_W'(A_VPER):    live.vper <= wr_data;
        ADDR_W'(A_VPW):     live.vpw  <= wr_data;
        ADDR_W'(A_DISP_H):  begin
          live.dh_end   <= wr_data[FIELD_W +: FIELD_W];
          live.dh_start <= wr_data[FIELD_W-1:0];
        end
        ADDR_W'(A_DISP_VS): live.dvs <= wr_data;
        ADDR_W'(A_DISP_VE): live.dve <= wr_data;
        ADDR_W'(A_ACT_H):   begin
          live.ah_end   <= wr_data[FIELD_W +: FIELD_W];
          live.ah_start <= wr_data[FIELD_W-1:0];
        end
        ADDR_W'(A_ACT_VS):  live.avs <= wr_data;
        ADDR_W'(A_ACT_VE):  live.ave <= wr_data;
        ADDR_W'(A_BORDER):  border <= wr_data[CW-1:0];
        ADDR_W'(A_UFLOW):   uflow  <= wr_data[CW-1:0];
        ADDR_W'(A_POLAR):   live.pol <= wr_data[2:0];
        ADDR_W'(A_CNT_EN):  cnt_en <= wr_data[1:0];
        ADDR_W'(A_FETCH):   live.fetch <= wr_data;
        default: ;
      endcase
    end
  end

  // Shadow set: follows the live set while stopped, loads at frame wrap while running (R12)
  always_ff @(posedge clk) begin
    if (rst)                    act <= '0;
    else if (!run || frame_wrap) act <= live;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_addr)
        ADDR_W'(A_RUN):     rd_data <= REG_W'(run);
        ADDR_W'(A_MODE):    rd_data <= {live.mode, {MODE_LSB{1'b0}}};
        ADDR_W'(A_HSYNC):   rd_data <= {live.htot, live.hsw};
        ADDR_W'(A_VPER):    rd_data <= live.vper;
        ADDR_W'(A_VPW):     rd_data <= live.vpw;
        ADDR_W'(A_DISP_H):  rd_data <= {live.dh_end, live.dh_start};
        ADDR_W'(A_DISP_VS): rd_data <= live.dvs;
        ADDR_W'(A_DISP_VE): rd_data <= live.dve;
        ADDR_W'(A_ACT_H):   rd_data <= {live.ah_end, live.ah_start};
        ADDR_W'(A_ACT_VS):  rd_data <= live.avs;
        ADDR_W'(A_ACT_VE):  rd_data <= live.ave;
        ADDR_W'(A_BORDER):  rd_data <= REG_W'(border);
        ADDR_W'(A_UFLOW):   rd_data <= REG_W'(uflow);
        ADDR_W'(A_POLAR):   rd_data <= REG_W'(live.pol);
        ADDR_W'(A_CNT_EN):  rd_data <= REG_W'(cnt_en);
        ADDR_W'(A_FETCH):   rd_data <= live.fetch;
        ADDR_W'(A_FRAMES):  rd_data <= run ? REG_W'(frame_cnt) : '0;
        ADDR_W'(A_LINES):   rd_data <= run ? REG_W'(line_cnt) : '0;
        default:            rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dte_counters.sv
module dte_counters
  import dte_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int LINE_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic [1:0]         cnt_en,
  input  logic [FIELD_W-1:0] htot,
  input  logic [REG_W-1:0]   vper,
  output logic [FIELD_W-1:0] hpos,
  output logic [REG_W-1:0]   fpos,
  output logic [LINE_W-1:0]  line_cnt,
  output logic [CNT_W-1:0]   frame_cnt,
  output logic               wrap
);
  assign wrap = run && (fpos == vper - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      hpos      <= '0;
      fpos      <= '0;
      line_cnt  <= '0;
      frame_cnt <= '0;
    end else if (wrap) begin
      hpos     <= '0;
      fpos     <= '0;
      line_cnt <= '0;
      if (cnt_en[0]) frame_cnt <= frame_cnt + 1'b1;
    end else begin
      fpos <= fpos + 1'b1;
      if (hpos == htot - 1'b1) begin
        hpos <= '0;
        if (cnt_en[1]) line_cnt <= line_cnt + 1'b1;
      end else begin
        hpos <= hpos + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dte_outgen.sv
module dte_outgen
  import dte_pkg::*;
#(
  parameter int CW = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic [2:0]         mode,
  input  logic [2:0]         pol,
  input  logic [FIELD_W-1:0] hsw,
  input  logic [FIELD_W-1:0] dh_start,
  input  logic [FIELD_W-1:0] dh_end,
  input  logic [FIELD_W-1:0] ah_start,
  input  logic [FIELD_W-1:0] ah_end,
  input  logic [REG_W-1:0]   vpw,
  input  logic [REG_W-1:0]   dvs,
  input  logic [REG_W-1:0]   dve,
  input  logic [REG_W-1:0]   avs,
  input  logic [REG_W-1:0]   ave,
  input  logic [REG_W-1:0]   fetch_at,
  input  logic [CW-1:0]      border,
  input  logic [CW-1:0]      uflow,
  input  logic [CW-1:0]      pix_in,
  input  logic               pix_valid,
  input  logic [FIELD_W-1:0] hpos,
  input  logic [REG_W-1:0]   fpos,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               de_o,
  output logic               fetch_o,
  output logic [CW-1:0]      pixel_o
);
  logic hs_raw, vs_raw, in_disp, in_act_h, in_act_v, in_act, fetch_raw;
  logic [CW-1:0] pix_next;

  always_comb begin
    hs_raw    = run && (hpos < hsw);
    vs_raw    = run && (fpos < vpw);
    in_disp   = run && (hpos >= dh_start) && (hpos <= dh_end) &&
                (fpos >= dvs) && (fpos <= dve);
    in_act_h  = !mode[0] || ((hpos >= ah_start) && (hpos <= ah_end));
    in_act_v  = !mode[1] || ((fpos >= avs) && (fpos <= ave));
    in_act    = in_disp && in_act_h && in_act_v;
    fetch_raw = run && mode[2] && (fpos == fetch_at);
    if (!in_disp)      pix_next = '0;
    else if (!in_act)  pix_next = border;
    else if (pix_valid) pix_next = pix_in;
    else               pix_next = uflow;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
      de_o    <= 1'b0;
      fetch_o <= 1'b0;
      pixel_o <= '0;
    end else begin
      hsync_o <= hs_raw ^ pol[0];
      vsync_o <= vs_raw ^ pol[1];
      de_o    <= in_disp ^ pol[2];
      fetch_o <= fetch_raw;
      pixel_o <= pix_next;
    end
  end
endmodule

// File: rtl/disp_timing_engine.sv
module disp_timing_engine
  import dte_pkg::*;
#(
  parameter int CW     = 24,
  parameter int CNT_W  = 32,
  parameter int LINE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic [CW-1:0]     pix_in,
  input  logic              pix_valid,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic              fetch_o,
  output logic [CW-1:0]     pixel_o
);
  timing_t             act;
  logic                run;
  logic [1:0]          cnt_en;
  logic [CW-1:0]       border, uflow;
  logic [FIELD_W-1:0]  hpos;
  logic [REG_W-1:0]    fpos;
  logic [LINE_W-1:0]   line_cnt;
  logic [CNT_W-1:0]    frame_cnt;
  logic                wrap;

  dte_regs #(.CW(CW), .CNT_W(CNT_W), .LINE_W(LINE_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .frame_wrap(wrap),
    .frame_cnt(frame_cnt), .line_cnt(line_cnt), .run(run), .cnt_en(cnt_en),
    .border(border), .uflow(uflow), .act(act)
  );

  dte_counters #(.CNT_W(CNT_W), .LINE_W(LINE_W)) u_cnt (
    .clk(clk), .rst(rst), .run(run), .cnt_en(cnt_en), .htot(act.htot),
    .vper(act.vper), .hpos(hpos), .fpos(fpos), .line_cnt(line_cnt),
    .frame_cnt(frame_cnt), .wrap(wrap)
  );

  dte_outgen #(.CW(CW)) u_out (
    .clk(clk), .rst(rst), .run(run), .mode(act.mode), .pol(act.pol),
    .hsw(act.hsw), .dh_start(act.dh_start), .dh_end(act.dh_end),
    .ah_start(act.ah_start), .ah_end(act.ah_end), .vpw(act.vpw),
    .dvs(act.dvs), .dve(act.dve), .avs(act.avs), .ave(act.ave),
    .fetch_at(act.fetch), .border(border), .uflow(uflow), .pix_in(pix_in),
    .pix_valid(pix_valid), .hpos(hpos), .fpos(fpos), .hsync_o(hsync_o),
    .vsync_o(vsync_o), .de_o(de_o), .fetch_o(fetch_o), .pixel_o(pixel_o)
  );
endmodule

// File: rtl/dte_checker.sv
module dte_checker
  import dte_pkg::*;
#(
  parameter int CW    = 24,
  parameter int CNT_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               run,
  input logic [FIELD_W-1:0] hpos,
  input logic [FIELD_W-1:0] htot,
  input logic [REG_W-1:0]   fpos,
  input logic [REG_W-1:0]   vper,
  input logic [CNT_W-1:0]   frame_cnt,
  input logic               fetch_o,
  input logic               de_o,
  input logic [2:0]         pol,
  input logic [CW-1:0]      pixel_o
);
  a_r2_hpos_in_range: assert property (@(posedge clk) disable iff (rst)
    (run && htot != '0) |-> (hpos < htot));

  a_r3_fpos_in_range: assert property (@(posedge clk) disable iff (rst)
    (run && vper != '0) |-> (fpos < vper));

  a_r4_dark_outside_window: assert property (@(posedge clk) disable iff (rst)
    ($stable(pol) && (de_o == pol[2])) |-> (pixel_o == '0));

  a_r9_fetch_single: assert property (@(posedge clk) disable iff (rst)
    (fetch_o && vper > 32'd1) |=> !fetch_o);

  a_r10_frame_step: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run)) |->
      ((frame_cnt == $past(frame_cnt)) || (frame_cnt == $past(frame_cnt) + 1'b1)));

  a_r11_idle_clears: assert property (@(posedge clk) disable iff (rst)
    !run |=> (frame_cnt == '0));
endmodule

bind disp_timing_engine dte_checker #(.CW(CW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .run(run), .hpos(hpos), .htot(act.htot),
  .fpos(fpos), .vper(act.vper), .frame_cnt(frame_cnt), .fetch_o(fetch_o),
  .de_o(de_o), .pol(act.pol), .pixel_o(pixel_o)
);

// File: tb/disp_timing_engine_tb_top.sv
`timescale 1ns/1ps
module disp_timing_engine_tb_top;
  localparam int CW = 24;
  localparam logic [23:0] C_BORDER = 24'h00B0B0;
  localparam logic [23:0] C_UFLOW  = 24'h0000FF;
  localparam logic [23:0] C_PIX    = 24'h123456;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic [CW-1:0] pix_in = C_PIX;
  logic pix_valid = 1'b1;
  logic hsync_o, vsync_o, de_o, fetch_o;
  logic [CW-1:0] pixel_o;

  int n_chk = 0;
  int n_bad = 0;
  logic vs_lvl = 1'b1;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  disp_timing_engine #(.CW(CW)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pix_in(pix_in), .pix_valid(pix_valid),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .fetch_o(fetch_o),
    .pixel_o(pixel_o)
  );

  task automatic chk(input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
    n_chk++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = 5'(a);
    @(negedge clk);
    d = rd_data;
  endtask

  function automatic logic sig(input int sel);
    case (sel)
      0: return hsync_o;
      1: return vsync_o;
      2: return de_o;
      default: return fetch_o;
    endcase
  endfunction

  // Returns at the first sample where sig(sel) has just become lvl
  task automatic sync_edge(input int sel, input logic lvl);
    logic prev;
    @(negedge clk);
    prev = sig(sel);
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (prev !== lvl && sig(sel) === lvl) return;
      prev = sig(sel);
    end
  endtask

  task automatic count_frame(input int sel, input logic lvl, output int n);
    n = 0;
    sync_edge(1, vs_lvl);
    for (int i = 0; i < 200; i++) begin
      if (sig(sel) === lvl) n++;
      @(negedge clk);
    end
  endtask

  task automatic first_after_vs(input int sel, input logic lvl, output int k);
    sync_edge(1, vs_lvl);
    k = 0;
    while (sig(sel) !== lvl && k < 400) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic pulse_len(input int sel, input logic lvl, output int len, output int period);
    sync_edge(sel, lvl);
    len = 0; period = 0;
    while (sig(sel) === lvl && len < 400) begin
      @(negedge clk); len++;
    end
    period = len;
    while (!(sig(sel) === lvl) && period < 800) begin
      @(negedge clk); period++;
    end
  endtask

  task automatic count_pix(output int n_act, output int n_bord, output int n_uf);
    n_act = 0; n_bord = 0; n_uf = 0;
    sync_edge(1, vs_lvl);
    for (int i = 0; i < 200; i++) begin
      if (de_o === 1'b1) begin
        if (pixel_o === C_PIX) n_act++;
        else if (pixel_o === C_BORDER) n_bord++;
        else if (pixel_o === C_UFLOW) n_uf++;
      end
      @(negedge clk);
    end
  endtask

  // 20-clock lines, 10 lines (200 clocks), display h 5..16, v lines 3..7
  task automatic program_base(input int skew, input logic [31:0] mode, input logic [2:0] pol);
    wr(0, 32'd0);
    wr(2, {16'd20, 16'd2});
    wr(3, 32'd200);
    wr(4, 32'd20);
    wr(5, {16'd16, 16'd5});
    wr(6, 32'(60 + skew));
    wr(7, 32'(159 + skew));
    wr(1, mode);
    wr(11, 32'(C_BORDER));
    wr(12, 32'(C_UFLOW));
    wr(13, 32'(pol));
    wr(14, 32'd3);
    wr(0, 32'd1);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(2, d); chk("R1 reset hsync reg", d, 0);
    rd(16, d); chk("R1 reset frame count", d, 0);
    chk("R6 reset idle hsync", 32'(hsync_o), 0);
    chk("R6 reset idle de", 32'(de_o), 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(2, {16'd20, 16'd2}); rd(2, d); chk("R1 hsync readback", d, {16'd20, 16'd2});
    wr(1, 32'hE000_0000); rd(1, d); chk("R1 mode readback", d, 32'hE000_0000);
    wr(1, 32'd0);
  endtask

  task automatic t_hv;
    int len, per;
    program_base(0, 0, 3'b000);
    pulse_len(0, 1'b1, len, per);
    chk("R2 hsync width", 32'(len), 2); chk("R2 hsync period", 32'(per), 20);
    pulse_len(1, 1'b1, len, per);
    chk("R3 vsync width", 32'(len), 20); chk("R3 frame period", 32'(per), 200);
    count_frame(2, 1'b1, len); chk("R4 de per frame", 32'(len), 60);
    first_after_vs(2, 1'b1, len); chk("R4 first de position", 32'(len), 65);
  endtask

  task automatic t_skew;
    int n;
    program_base(8, 0, 3'b000);
    first_after_vs(2, 1'b1, n); chk("R5 skewed first de", 32'(n), 68);
    count_frame(2, 1'b1, n); chk("R5 skewed de count", 32'(n), 60);
  endtask

  task automatic t_pol;
    int len, per;
    program_base(0, 0, 3'b111);
    vs_lvl = 1'b0;
    pulse_len(0, 1'b0, len, per);
    chk("R6 inverted hsync width", 32'(len), 2); chk("R6 inverted hsync period", 32'(per), 20);
    count_frame(2, 1'b0, len); chk("R6 inverted de count", 32'(len), 60);
    wr(0, 32'd0);
    repeat (3) @(negedge clk);
    chk("R6 idle hsync inverted", 32'(hsync_o), 1);
    chk("R6 idle de inverted", 32'(de_o), 1);
    vs_lvl = 1'b1;
  endtask

  task automatic t_active;
    int a, b, u;
    program_base(0, 32'h6000_0000, 3'b000);
    wr(0, 32'd0);
    wr(8, {16'd10, 16'd7});
    wr(9, 32'd80);
    wr(10, 32'd119);
    wr(0, 32'd1);
    count_pix(a, b, u);
    chk("R7 active both axes", 32'(a), 8); chk("R7 border both axes", 32'(b), 52);
    wr(0, 32'd0); wr(1, 32'h2000_0000); wr(0, 32'd1);
    count_pix(a, b, u);
    chk("R7 active h only", 32'(a), 20); chk("R7 border h only", 32'(b), 40);
  endtask

  task automatic t_uflow;
    int a, b, u;
    program_base(0, 0, 3'b000);
    pix_valid = 1'b0;
    count_pix(a, b, u);
    chk("R8 underflow pixels", 32'(u), 60); chk("R8 no live pixels", 32'(a), 0);
    pix_valid = 1'b1;
  endtask

  task automatic t_fetch;
    int n;
    program_base(0, 32'h8000_0000, 3'b000);
    wr(0, 32'd0); wr(15, 32'd10); wr(0, 32'd1);
    count_frame(3, 1'b1, n); chk("R9 fetch pulses per frame", 32'(n), 1);
    first_after_vs(3, 1'b1, n); chk("R9 fetch position", 32'(n), 10);
    wr(0, 32'd0); wr(1, 32'd0); wr(0, 32'd1);
    count_frame(3, 1'b1, n); chk("R9 fetch off", 32'(n), 0);
  endtask

  task automatic t_counters;
    logic [31:0] f1, f2, l1, l2;
    program_base(0, 0, 3'b000);
    sync_edge(1, 1'b1); rd(16, f1);
    repeat (3) sync_edge(1, 1'b1);
    rd(16, f2); chk("R10 frames advance by 3", f2 - f1, 3);
    sync_edge(1, 1'b1);
    repeat (45) @(negedge clk);
    rd(17, l1);
    repeat (18) @(negedge clk);
    rd(17, l2);
    chk("R10 line count mid frame", l1, 2);
    chk("R10 line step", l2 - l1, 1);
    wr(14, 32'd0);
    rd(16, f1);
    repeat (2) sync_edge(1, 1'b1);
    rd(16, f2); chk("R10 frame hold when disabled", f2 - f1, 0);
    // R11: stop, counts read zero, de inactive
    wr(0, 32'd0);
    rd(16, f1); chk("R11 frames zero when stopped", f1, 0);
    rd(17, l1); chk("R11 lines zero when stopped", l1, 0);
    begin
      int n = 0;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (de_o !== 1'b0) n++;
      end
      chk("R11 de inactive when stopped", 32'(n), 0);
    end
  endtask

  task automatic t_shadow;
    int len, per;
    program_base(0, 0, 3'b000);
    sync_edge(1, 1'b1);
    repeat (48) @(negedge clk);
    wr(2, {16'd24, 16'd2});
    pulse_len(0, 1'b1, len, per);
    chk("R12 old period until wrap", 32'(per), 20);
    sync_edge(1, 1'b1);
    pulse_len(0, 1'b1, len, per);
    chk("R12 new period after wrap", 32'(per), 24);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_regs();
    t_hv();
    t_skew();
    t_pol();
    t_active();
    t_uflow();
    t_fetch();
    t_counters();
    t_shadow();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule